// File: doc/BRIEF.md
# Fourier Linear Combiner Noise Canceller

This block removes a periodic disturbance from a stream of samples. It models the disturbance as the sum of a sine reference scaled by one weight and a cosine reference scaled by a second weight. It subtracts that model from the bias-corrected sample, and the difference is the error. The block then adapts both weights with a least-mean-squares step, scaled by a programmable step size. The next sample sees the adapted weights.

A host presents a sample, a step size and a bias, and raises a one-cycle valid strobe. One pair of saturating multipliers and one adder are shared between two cycles of work. The first cycle forms the estimate and the error. The second cycle updates the weights. A done strobe then marks the result. The references come from a computed quarter-wave table that is indexed by a phase counter. The counter steps once per sample. All values are signed fixed point with 12 fraction bits in a 16-bit word (Q4.12).

Top module: `fcl_canceller`

## Requirements
- R1: While reset is asserted, and after it is released, `est_out` and `err_out` are 0 and `done_out` is low. Both weights and the phase counter are 0, so the first sample after reset has estimate 0 and uses phase 0.
- R2: The error is sub(sub(sample, bias), estimate), where sub(a,b) is a-b clamped to [-32768, 32767].
- R3: The estimate is add(mul(w1, S), mul(w2, C)). Here mul(a,b) is (a*b) shifted arithmetically right by 12, then clamped, and add is a clamped sum.
- R4: Let j = p mod 32 and q = j*(32-j). The sine reference for phase p is floor(65536*q/(5120-4*q)), negated for p >= 32. The cosine reference at p is the sine reference at (p+16) mod 64. The phase counter advances by one per accepted sample and wraps from 63 to 0.
- R5: After the estimate, with g = mul(mu, error), the block sets w1 to add(w1, mul(g, S)) and w2 to add(w2, mul(g, C)). S and C are the references of the same sample, and the weights change at no other time.
- R6: Let edge A be the rising edge that samples `smp_valid` high while idle. `est_out` and `err_out` take their new values on the next rising edge and hold until the following sample. `done_out` is high for exactly the one cycle after the second rising edge following A.
- R7: Sample, step size and bias are captured on the falling clock edge. The values used are those present at the falling edge just before A. A valid strobe or input change that arrives while a sample is in progress is ignored.
- R8: Every multiply, add and subtract saturates to [-32768, 32767] instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe, honoured only while idle |
| smp_in | input | 16 | Input sample, Q4.12 |
| step_mu | input | 16 | Adaptation step size, Q4.12 |
| bias_in | input | 16 | Bias subtracted from the sample, Q4.12 |
| est_out | output | 16 | Disturbance estimate, Q4.12 |
| err_out | output | 16 | Error (cleaned sample), Q4.12 |
| done_out | output | 1 | One-cycle result strobe |

## Verification
The assertions watch several properties on every cycle. The done strobe never lasts more than one cycle. The phase steps by exactly one with each result. The weights, estimate and error change only in their own step. The captured inputs stay frozen while a sample is in progress, and the estimate step is entered only from idle. The bench covers what only an end-to-end comparison can reveal. It checks the numerical values of the estimate and error against a reference model across a phase wrap. It checks convergence on a synthetic sinusoid, saturation at both rails, inputs that are changed mid-sample and must be ignored, and a reset in the middle of a run.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EST  = 2'd1,
    ST_UPD  = 2'd2
  } fcl_state_e;
endpackage

// File: rtl/fcl_ref_table.sv
module fcl_ref_table #(
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter int PB   = 6
) (
  input  logic [PB-1:0]         phase,
  output logic signed [W-1:0]   sin_o,
  output logic signed [W-1:0]   cos_o
);
  localparam int N    = 1 << PB;
  localparam int HALF = N / 2;
  localparam int QTR  = N / 4;

  // quarter-wave magnitude from a rational sine approximation
  function automatic int qval(input int j);
    int q;
    q = j * (HALF - j);
    return (16 * (1 << FRAC) * q) / (5 * HALF * HALF - 4 * q);
  endfunction

  logic signed [W-1:0] qtab [QTR+1];
  for (genvar j = 0; j <= QTR; j++) begin : g_tab
    assign qtab[j] = W'(qval(j));
  end

  logic [PB-1:0]       addr [2];
  logic signed [W-1:0] refv [2];
  assign addr[0] = phase;
  assign addr[1] = phase + PB'(QTR);

  for (genvar k = 0; k < 2; k++) begin : g_look
    logic [PB-3:0]       idx;
    logic [PB-2:0]       mir;
    logic signed [W-1:0] mag;
    assign idx     = addr[k][PB-3:0];
    assign mir     = (PB-1)'(QTR) - (PB-1)'(idx);
    assign mag     = addr[k][PB-2] ? qtab[mir] : qtab[idx];
    assign refv[k] = addr[k][PB-1] ? -mag : mag;
  end

  assign sin_o = refv[0];
  assign cos_o = refv[1];
endmodule

// File: rtl/fcl_mul_lanes.sv
module fcl_mul_lanes #(
  parameter int W     = 16,
  parameter int FRAC  = 12,
  parameter int LANES = 2
) (
  input  logic signed [W-1:0] a [LANES],
  input  logic signed [W-1:0] b [LANES],
  output logic signed [W-1:0] p [LANES]
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] HI = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [PW-1:0] full;
    logic signed [PW-1:0] sh;
    assign full = PW'(a[i]) * PW'(b[i]);
    assign sh   = full >>> FRAC;
    always_comb begin
      if (sh > HI)      p[i] = HI[W-1:0];
      else if (sh < LO) p[i] = LO[W-1:0];
      else              p[i] = sh[W-1:0];
    end
  end
endmodule

// File: rtl/fcl_canceller.sv
module fcl_canceller #(
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter int PB   = 6
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_in,
  input  logic signed [W-1:0] step_mu,
  input  logic signed [W-1:0] bias_in,
  output logic signed [W-1:0] est_out,
  output logic signed [W-1:0] err_out,
  output logic                done_out
);
  import fcl_pkg::*;

  function automatic logic signed [W-1:0] sat_sum(input logic signed [W-1:0] x,
                                                  input logic signed [W-1:0] y,
                                                  input logic neg);
    logic signed [W:0] s;
    s = neg ? ((W+1)'(x) - (W+1)'(y)) : ((W+1)'(x) + (W+1)'(y));
    if (s[W] != s[W-1]) return s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    return s[W-1:0];
  endfunction

  // reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  fcl_state_e          st_q, st_d;
  logic [PB-1:0]       phase_q;
  logic signed [W-1:0] dat_q, mu_q, bias_q;
  logic signed [W-1:0] w1_q, w2_q, est_q, err_q;
  logic                done_q;

  // falling-edge input capture, only while idle
  logic cap_en;
  assign cap_en = smp_valid && (st_q == ST_IDLE);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      mu_q   <= '0;
      bias_q <= '0;
    end else if (cap_en) begin
      dat_q  <= smp_in;
      mu_q   <= step_mu;
      bias_q <= bias_in;
    end
  end

  // references
  logic signed [W-1:0] sin_r, cos_r;
  fcl_ref_table #(.W(W), .FRAC(FRAC), .PB(PB)) u_ref (
    .phase(phase_q), .sin_o(sin_r), .cos_o(cos_r)
  );

  // adaptation gain mu*e from the registered error
  logic signed [W-1:0] g_a [1];
  logic signed [W-1:0] g_b [1];
  logic signed [W-1:0] g_p [1];
  assign g_a[0] = mu_q;
  assign g_b[0] = err_q;
  fcl_mul_lanes #(.W(W), .FRAC(FRAC), .LANES(1)) u_gain (
    .a(g_a), .b(g_b), .p(g_p)
  );

  // shared product pair: weights*refs in EST, gain*refs in UPD
  logic signed [W-1:0] m_a [2];
  logic signed [W-1:0] m_b [2];
  logic signed [W-1:0] m_p [2];
  logic                upd_sel;
  assign upd_sel = (st_q == ST_UPD);
  assign m_a[0]  = upd_sel ? g_p[0] : w1_q;
  assign m_a[1]  = upd_sel ? g_p[0] : w2_q;
  assign m_b[0]  = sin_r;
  assign m_b[1]  = cos_r;
  fcl_mul_lanes #(.W(W), .FRAC(FRAC), .LANES(2)) u_mul (
    .a(m_a), .b(m_b), .p(m_p)
  );

  // shared adder: estimate sum in EST, w1 step in UPD
  logic signed [W-1:0] add_x, add_y, add_s;
  logic signed [W-1:0] corr, err_d, w2_d;
  assign add_x = upd_sel ? w1_q : m_p[0];
  assign add_y = upd_sel ? m_p[0] : m_p[1];
  assign add_s = sat_sum(add_x, add_y, 1'b0);
  assign corr  = sat_sum(dat_q, bias_q, 1'b1);
  assign err_d = sat_sum(corr, add_s, 1'b1);
  assign w2_d  = sat_sum(w2_q, m_p[1], 1'b0);

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (smp_valid) st_d = ST_EST;
      ST_EST:  st_d = ST_UPD;
      ST_UPD:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  logic est_en, upd_en;
  assign est_en = (st_q == ST_EST);
  assign upd_en = (st_q == ST_UPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      est_q   <= '0;
      err_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= upd_en;
      if (est_en) begin
        est_q <= add_s;
        err_q <= err_d;
      end
      if (upd_en) begin
        w1_q    <= add_s;
        w2_q    <= w2_d;
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign est_out  = est_q;
  assign err_out  = err_q;
  assign done_out = done_q;

  // R6: result strobe lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4: phase advances by exactly one with each result
  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == $past(phase_q) + 1'b1));

  // R5: weights move only in the update step
  p_weight_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) != ST_UPD) |-> ($stable(w1_q) && $stable(w2_q)));

  // R6: estimate and error move only in the estimate step
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) != ST_EST) |-> ($stable(est_q) && $stable(err_q)));

  // R7: captured inputs are frozen while the update runs
  p_inputs_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EST) |=> ($stable(dat_q) && $stable(mu_q) && $stable(bias_q)));

  // R7: the estimate step is entered only from idle
  p_accept_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EST) |-> ($past(st_q) == ST_IDLE));
endmodule

// File: tb/tb_fcl_canceller.sv
module tb_fcl_canceller;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               arst_n;
  logic               smp_valid;
  logic signed [15:0] smp_in, step_mu, bias_in;
  logic signed [15:0] est_out, err_out;
  logic               done_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  int  w1_m, w2_m, ph_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcl_canceller dut (
    .clk(clk), .arst_n(arst_n), .smp_valid(smp_valid), .smp_in(smp_in),
    .step_mu(step_mu), .bias_in(bias_in), .est_out(est_out),
    .err_out(err_out), .done_out(done_out)
  );

  function automatic int sat16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic int mulq(input int a, input int b);
    return sat16((a * b) >>> 12);
  endfunction
  function automatic int addq(input int a, input int b);
    return sat16(a + b);
  endfunction
  function automatic int subq(input int a, input int b);
    return sat16(a - b);
  endfunction
  function automatic int sine_ref(input int p);
    int j, q, v;
    j = p % 32;
    q = j * (32 - j);
    v = (65536 * q) / (5120 - 4 * q);
    return (p >= 32) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    w1_m = 0; w2_m = 0; ph_m = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    arst_n = 1'b0; smp_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    model_reset();
    @(negedge clk);
    chk(est_out == 0, "R1 est after reset", int'(est_out), 0);
    chk(err_out == 0, "R1 err after reset", int'(err_out), 0);
    chk(done_out == 1'b0, "R1 done after reset", int'(done_out), 0);
  endtask

  // one sample; inject = change inputs and hold valid high mid-sample (R7)
  task automatic run_sample(input int d, input int m, input int o, input bit inject,
                            input string tag);
    int s, c, e_est, e_err, g;
    s     = sine_ref(ph_m);
    c     = sine_ref((ph_m + 16) % 64);
    e_est = addq(mulq(w1_m, s), mulq(w2_m, c));          // R3
    e_err = subq(subq(d, o), e_est);                      // R2, R8
    @(posedge clk); #1;
    smp_valid = 1'b1; smp_in = 16'(d); step_mu = 16'(m); bias_in = 16'(o);
    @(posedge clk);                                       // accepting edge
    #1;
    if (inject) begin
      smp_in = 16'(d ^ 16'h5a5a); step_mu = 16'(~m); bias_in = 16'(o + 777);
    end else smp_valid = 1'b0;
    @(negedge clk);
    chk(done_out == 1'b0, {"R6 done early ", tag}, int'(done_out), 0);
    @(posedge clk);
    @(negedge clk);
    chk(int'(est_out) == e_est, {"R3 estimate ", tag}, int'(est_out), e_est);
    chk(int'(err_out) == e_err, {"R2 error ", tag}, int'(err_out), e_err);
    chk(done_out == 1'b0, {"R6 done before update ", tag}, int'(done_out), 0);
    @(posedge clk); #1;
    smp_valid = 1'b0;
    @(negedge clk);
    chk(done_out == 1'b1, {"R6 done pulse ", tag}, int'(done_out), 1);
    @(negedge clk);
    chk(done_out == 1'b0, {"R6 done single ", tag}, int'(done_out), 0);
    chk(int'(err_out) == e_err, {"R7 error held ", tag}, int'(err_out), e_err);
    // R5 weight update in the model
    g    = mulq(m, e_err);
    w1_m = addq(w1_m, mulq(g, s));
    w2_m = addq(w2_m, mulq(g, c));
    ph_m = (ph_m + 1) % 64;                               // R4
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    arst_n = 1'b0; smp_valid = 1'b0;
    smp_in = '0; step_mu = '0; bias_in = '0;
    do_reset();                                           // R1

    // directed: synthetic disturbance, converging weights, phase wrap (R4, R5)
    for (int i = 0; i < 72; i++) begin
      int d, noise;
      noise = int'($urandom_range(127)) - 64;
      d = 5120 + (3 * sine_ref(ph_m) - sine_ref((ph_m + 16) % 64)) / 2 + noise;
      run_sample(d, 410, 5120, (i % 7) == 3, "sinusoid");
    end

    // saturation at both rails (R8)
    run_sample(32767, 32767, -32768, 1'b0, "R8 high rail");
    run_sample(32767, 32767, -32768, 1'b0, "R8 high rail 2");
    run_sample(-32768, 32767, 32767, 1'b0, "R8 low rail");
    run_sample(-32768, 32767, 32767, 1'b1, "R8 low rail inj");

    // reset mid-run: weights and phase cleared (R1)
    do_reset();
    run_sample(1000, 410, 0, 1'b0, "R1 first after reset");

    // constrained random, with mid-sample input changes (R7)
    for (int i = 0; i < 60; i++) begin
      int d, m, o;
      d = int'($urandom_range(65535)) - 32768;
      m = int'($urandom_range(8191));
      o = int'($urandom_range(16383)) - 8192;
      run_sample(d, m, o, ($urandom_range(3) == 0), "random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule